// File: doc/BRIEF.md
# Endpoint Interrupt Priority Arbiter

This block sits between the per-endpoint status logic of a USB device controller and its interrupt reporting. Each endpoint supplies a transmit-complete flag, a receive-complete flag and a class bit. The class bit is set for isochronous endpoints and for bulk endpoints that use two buffers. On every clock the arbiter picks one requesting endpoint and reports its number, the direction of the completed transfer, and a single interrupt line that goes high whenever any endpoint has a completed transfer pending.

Selection has two levels. Any requesting endpoint whose class bit is set beats every endpoint whose class bit is clear. Inside each of the two groups, the endpoint with the lowest number wins. Interrupt software can therefore read one identifier and one direction bit, service that endpoint, clear its flag, and read again. The outputs are registered once, so they follow the inputs with one clock of delay. They are meant to be read-only status.

Top module: `ep_irq_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `irq_o`, `dir_o` and `ep_id_o` become 0 after that edge, whatever the request inputs are.
- R2: An endpoint requests service when its `tx_done` bit or its `rx_done` bit is 1. `irq_o` is 1 exactly when at least one endpoint requested service at the previous rising edge.
- R3: When any requesting endpoint has its `ep_class_hi` bit at 1, `ep_id_o` names one of those endpoints, even if a lower-numbered endpoint with class bit 0 is also requesting.
- R4: Within the group chosen by R3, `ep_id_o` is the lowest requesting endpoint number, with endpoint 0 highest. The number is given as an unsigned 4-bit binary value.
- R5: `dir_o` is 0 when the selected endpoint has only `tx_done` set, which marks an IN transfer.
- R6: `dir_o` is 1 when the selected endpoint has `rx_done` set, whether or not its `tx_done` is also set.
- R7: Whenever `irq_o` is 0, `ep_id_o` and `dir_o` are both 0.
- R8: The class bit of an endpoint that is not requesting has no effect on the outputs.
- R9: The outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, so an input change becomes visible one clock later.
- R10: Endpoint 15, the highest number, can be selected and reported as 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_done | input | 16 | Transmit-complete flag, one bit per endpoint (bit n is endpoint n) |
| rx_done | input | 16 | Receive-complete flag, one bit per endpoint |
| ep_class_hi | input | 16 | 1 for an isochronous or two-buffer bulk endpoint, giving it the upper priority group |
| irq_o | output | 1 | Correct-transfer interrupt, high while any request is pending |
| ep_id_o | output | 4 | Number of the selected endpoint |
| dir_o | output | 1 | Direction of the selected transfer: 0 = IN (transmit only), 1 = receive pending |

## Verification
The selection function is driven with four kinds of pattern. Single requests at the low, middle and top endpoint numbers show that the index is encoded correctly. Several requests in the same group show that the lowest number wins. Mixed groups where the lower-numbered endpoint is in the lower group show that the class decides before the index. Class bits set on idle endpoints show that only requesting endpoints take part. The direction is tried with transmit only, receive only and both flags on the selected endpoint, which separates a design that looks only at the receive flag from one that uses the flags of the wrong endpoint. The timing checks sample just before and just after an edge to expose a missing or an extra register, and a reset asserted while requests are active shows that the reset is synchronous and takes priority.

// File: rtl/ep_arb_pkg.sv
// Package: ep_arb_pkg
// Holds the default sizing of the endpoint arbiter and a helper that
// derives the identifier width from the endpoint count.
// Assumes at least two endpoints.
package ep_arb_pkg;

    parameter int unsigned EP_COUNT_DEF = 16;

    // Width needed to number count endpoints (minimum 1).
    function automatic int unsigned id_width(input int unsigned count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

    // One tier's candidate: whether anyone requested, and the winner.
    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } tier_pick_t;

endpackage

// File: rtl/ep_first_finder.sv
// Module: ep_first_finder
// Finds the lowest set bit of a request vector and reports its index.
// Purely combinational. Assumes ID_W is wide enough to number N bits.
module ep_first_finder #(
    parameter int unsigned N    = 16,
    parameter int unsigned ID_W = 4
) (
    input  logic [N-1:0]    req,
    output logic            found,
    output logic [ID_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end

    // R4: the winner must be a set bit with no set bit below it.
    always_comb begin
        if (found) begin
            a_r4_lowest_wins: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
        a_r2_found_any: assert (found == (|req));
    end

endmodule

// File: rtl/ep_tier_select.sv
// Module: ep_tier_select
// Splits the requesting endpoints into the upper (class bit set) and lower
// groups, finds the lowest requester in each group, lets the upper group
// win, and reads the direction from the winner's receive flag.
// Combinational. Assumes the flags are stable around the sampling edge.
module ep_tier_select #(
    parameter int unsigned N    = 16,
    parameter int unsigned ID_W = 4
) (
    input  logic [N-1:0]    tx_done,
    input  logic [N-1:0]    rx_done,
    input  logic [N-1:0]    class_hi,
    output logic            any_req,
    output logic [ID_W-1:0] win_id,
    output logic            win_dir
);

    localparam int unsigned TIERS = 2;

    logic [N-1:0]    req_all;
    logic [N-1:0]    tier_req [TIERS];
    logic            tier_hit [TIERS];
    logic [ID_W-1:0] tier_idx [TIERS];

    // Form the request vector and the two group masks.
    always_comb begin
        req_all     = tx_done | rx_done;
        tier_req[0] = req_all & class_hi;
        tier_req[1] = req_all & ~class_hi;
    end

    // One lowest-index finder per priority group.
    for (genvar t = 0; t < TIERS; t++) begin : g_tier
        ep_first_finder #(
            .N    (N),
            .ID_W (ID_W)
        ) i_finder (
            .req   (tier_req[t]),
            .found (tier_hit[t]),
            .idx   (tier_idx[t])
        );
    end

    // Upper group first, then the lower group; direction from rx of the winner.
    always_comb begin
        any_req = tier_hit[0] | tier_hit[1];
        if (tier_hit[0]) begin
            win_id = tier_idx[0];
        end else if (tier_hit[1]) begin
            win_id = tier_idx[1];
        end else begin
            win_id = '0;
        end
        win_dir = any_req & rx_done[win_id];
    end

    // R3: if any upper-group endpoint requests, the winner carries the class bit.
    always_comb begin
        if (|tier_req[0]) begin
            a_r3_class_first: assert (class_hi[win_id] && req_all[win_id]);
        end
    end

endmodule

// File: rtl/ep_irq_arbiter.sv
// Module: ep_irq_arbiter
// Top of the endpoint interrupt arbiter: registers the two-group selection
// once per clock and drives the interrupt line, endpoint number and
// direction. Synchronous active-low reset. Assumes the flag inputs are
// synchronous to clk.
module ep_irq_arbiter #(
    parameter int unsigned NUM_EP = ep_arb_pkg::EP_COUNT_DEF,
    parameter int unsigned ID_W   = ep_arb_pkg::id_width(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] tx_done,
    input  logic [NUM_EP-1:0] rx_done,
    input  logic [NUM_EP-1:0] ep_class_hi,
    output logic              irq_o,
    output logic [ID_W-1:0]   ep_id_o,
    output logic              dir_o
);

    logic            sel_any;
    logic [ID_W-1:0] sel_id;
    logic            sel_dir;

    ep_tier_select #(
        .N    (NUM_EP),
        .ID_W (ID_W)
    ) i_select (
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .class_hi (ep_class_hi),
        .any_req  (sel_any),
        .win_id   (sel_id),
        .win_dir  (sel_dir)
    );

    // Register the selection; idle or reset forces all outputs to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_any) begin
            irq_o   <= 1'b0;
            ep_id_o <= '0;
            dir_o   <= 1'b0;
        end else begin
            irq_o   <= 1'b1;
            ep_id_o <= sel_id;
            dir_o   <= sel_dir;
        end
    end

    // Copies of the sampled inputs, kept only for the checks below.
    logic [NUM_EP-1:0] req_d;
    logic [NUM_EP-1:0] rx_d;
    logic [NUM_EP-1:0] cls_d;

    // Capture what the registered outputs were computed from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d <= '0;
            rx_d  <= '0;
            cls_d <= '0;
        end else begin
            req_d <= tx_done | rx_done;
            rx_d  <= rx_done;
            cls_d <= ep_class_hi;
        end
    end

    a_r2_irq_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|req_d));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (ep_id_o == '0 && !dir_o));

    a_r6_dir_matches_rx: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (dir_o == rx_d[ep_id_o]));

    a_r3_upper_group_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && |(req_d & cls_d)) |-> (cls_d[ep_id_o] && req_d[ep_id_o]));

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && ep_id_o == '0 && !dir_o));

endmodule

// File: tb/test_ep_irq_arbiter.sv
// Directed bench for ep_irq_arbiter: one task per scenario, each checking
// its own results against a model built from the requirements.
module test_ep_irq_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] tx_done = '0;
    logic [N-1:0] rx_done = '0;
    logic [N-1:0] ep_class_hi = '0;
    logic         irq_o;
    logic [3:0]   ep_id_o;
    logic         dir_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ep_irq_arbiter i_ep_irq_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_done     (tx_done),
        .rx_done     (rx_done),
        .ep_class_hi (ep_class_hi),
        .irq_o       (irq_o),
        .ep_id_o     (ep_id_o),
        .dir_o       (dir_o)
    );

    // Compare the three outputs with expected values.
    task automatic check(input string req, input logic e_irq, input logic [3:0] e_id, input logic e_dir);
        n_tests++;
        if (irq_o !== e_irq || ep_id_o !== e_id || dir_o !== e_dir) begin
            n_fail++;
            $display("FAIL %s: got irq=%0b id=%0d dir=%0b, expected irq=%0b id=%0d dir=%0b",
                     req, irq_o, ep_id_o, dir_o, e_irq, e_id, e_dir);
        end
    endtask

    // Model from the requirements: upper group first, then lowest index.
    task automatic model(input logic [N-1:0] tx, input logic [N-1:0] rx, input logic [N-1:0] cl,
                         output logic m_irq, output logic [3:0] m_id, output logic m_dir);
        logic [N-1:0] rq;
        rq = tx | rx;
        m_irq = |rq; m_id = '0; m_dir = 1'b0;
        if (|(rq & cl)) begin
            for (int i = 0; i < N; i++) if (rq[i] && cl[i]) begin m_id = 4'(i); break; end
        end else begin
            for (int i = 0; i < N; i++) if (rq[i]) begin m_id = 4'(i); break; end
        end
        if (m_irq) m_dir = rx[m_id];
    endtask

    // Drive at the falling edge, pass one rising edge, sample at the next falling edge.
    task automatic apply(input string req, input logic [N-1:0] tx, input logic [N-1:0] rx,
                         input logic [N-1:0] cl);
        logic e_irq; logic [3:0] e_id; logic e_dir;
        @(negedge clk);
        tx_done = tx; rx_done = rx; ep_class_hi = cl;
        model(tx, rx, cl, e_irq, e_id, e_dir);
        @(negedge clk);
        check(req, e_irq, e_id, e_dir);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_done = 16'hFFFF; rx_done = 16'hFFFF; ep_class_hi = 16'h00FF;
        @(negedge clk);
        check("R1 reset with requests", 1'b0, 4'd0, 1'b0);
        rst_n = 1'b1; tx_done = '0; rx_done = '0; ep_class_hi = '0;
        @(negedge clk);
        check("R7 idle after reset", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_single();
        apply("R2 R5 single tx ep5", 16'h0020, 16'h0000, 16'h0000);
        check("R5 tx-only gives dir 0", 1'b1, 4'd5, 1'b0);
        apply("R6 rx-only ep9", 16'h0000, 16'h0200, 16'h0000);
        check("R6 rx-only gives dir 1", 1'b1, 4'd9, 1'b1);
        apply("R6 both flags ep3", 16'h0008, 16'h0008, 16'h0000);
        check("R6 tx+rx gives dir 1", 1'b1, 4'd3, 1'b1);
        apply("R10 top endpoint", 16'h8000, 16'h0000, 16'h0000);
        check("R10 ep15 reported", 1'b1, 4'd15, 1'b0);
        apply("R4 ep0 alone", 16'h0000, 16'h0001, 16'h0000);
    endtask

    task automatic t_priority();
        apply("R3 upper group beats lower index", 16'h0002, 16'h4000, 16'h4000);
        check("R3 ep14 over ep1", 1'b1, 4'd14, 1'b1);
        apply("R4 lowest in upper group", 16'h0084, 16'h0000, 16'h0084);
        check("R4 ep2 over ep7", 1'b1, 4'd2, 1'b0);
        apply("R4 lowest in lower group", 16'h0810, 16'h0010, 16'h0000);
        check("R4 ep4 over ep11", 1'b1, 4'd4, 1'b1);
        apply("R3 mixed dirs", 16'h0001, 16'h8000, 16'h8000);
        check("R3 ep15 upper over ep0", 1'b1, 4'd15, 1'b1);
        apply("R8 idle class bits ignored", 16'h0040, 16'h0000, 16'h803F);
        check("R8 ep6 chosen", 1'b1, 4'd6, 1'b0);
        apply("R2 R7 all idle", 16'h0000, 16'h0000, 16'hFFFF);
        check("R7 idle zeros", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_timing();
        apply("R9 setup ep8", 16'h0100, 16'h0000, 16'h0000);
        @(negedge clk);
        tx_done = 16'h0000; rx_done = 16'h1000;
        #(CLK_PERIOD / 2 - 1);
        check("R9 unchanged before edge", 1'b1, 4'd8, 1'b0);
        @(negedge clk);
        check("R9 updated after edge", 1'b1, 4'd12, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #(CLK_PERIOD / 2 - 1);
        check("R1 reset is synchronous", 1'b1, 4'd12, 1'b1);
        @(negedge clk);
        check("R1 mid-run reset clears", 1'b0, 4'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_timing();
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

endmodule